// File: doc/BRIEF.md
# Configuration image revision selector

This block decides which of up to four configuration images, held back to back in a boot memory, is the one the memory serves. A two-bit revision number comes either from two external select pins or from two internal programmable bits. A source-enable input picks between them. The number is not followed continuously. It is latched once when power-on reset ends, and again only when one of these events occurs:
- a rising edge on chip-enable;
- a falling edge on output-enable/reset while chip-enable is low;
- a rising edge on the configure strobe while chip-enable is low;
- a rising edge on the JTAG reconfigure pulse.

A size table is loaded while reset is held. It gives the length of each image in whole 8 Mb units. From it the block derives the start address of the latched revision, in the same units, and judges whether a requested revision exists. A revision exists when its size is nonzero and it ends within the memory capacity. A request for a revision that does not exist sets an invalid flag and keeps the revision that was latched before.

Top module: `rev_select`

## Requirements
- R1: When power-on reset is released, the selection is captured once with no strobe activity. Its result is on the outputs by the third rising clock edge after release. During reset the revision output is 0 and the invalid flag is 0.
- R2: When source-enable is 0, a capture takes the revision from the external pins. When source-enable is 1, it takes it from the internal bits. The encoding is binary: value 00 is revision 0, 01 is 1, 10 is 2 and 11 is 3.
- R3: A rising edge on chip-enable causes a capture.
- R4: A falling edge on output-enable/reset causes a capture only while chip-enable is low. While chip-enable is high it has no effect.
- R5: A rising edge on the configure strobe causes a capture only while chip-enable is low. While chip-enable is high it has no effect.
- R6: A rising edge on the JTAG reconfigure input causes a capture whatever the level of chip-enable.
- R7: Without a capture event, the following leave the revision output unchanged:
  - changes on the select pins, the internal bits or source-enable;
  - a falling edge of chip-enable.
- R8: The start address equals the sum of the table sizes of all lower-numbered revisions, counted in 8 Mb units. Table entry N sits at bits [4N+3:4N] of the table input.
- R9: A capture of a revision whose size is zero, or whose end (start plus size) exceeds the capacity of 8 units, sets the invalid flag and leaves the revision unchanged. A capture of an existing revision clears the flag.
- R10: A strobe change applied between clock edges is first reflected in the outputs after the third following rising edge. After the second edge the outputs are still unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; loads the size table |
| ext_sel | input | 2 | External revision select pins |
| int_sel | input | 2 | Internal programmable revision bits |
| src_int | input | 1 | 1 selects the internal bits, 0 the pins |
| ce | input | 1 | Chip-enable level (low = enabled) |
| oe_rst | input | 1 | Output-enable/reset strobe |
| cf | input | 1 | Configure strobe |
| jtag_reconf | input | 1 | JTAG reconfigure request |
| size_tbl | input | 16 | Four 4-bit image sizes in 8 Mb units |
| rev | output | 2 | Latched revision number |
| start_addr | output | 6 | Start of the latched image in 8 Mb units |
| rev_invalid | output | 1 | Last capture asked for a missing revision |

## Verification
The selection inputs are sampled in the cycle of the capture, two clocks after a strobe changes. The assertions therefore take for granted that the selection inputs, the pins, bits and source-enable, are stable across that window. The bench changes them only while all strobes are quiet and holds them until the result is checked. The assertions also assume that the configure and JTAG strobes are low, and chip-enable is low, when reset is released, so that no false edge follows reset. The size table is taken to be constant outside reset. The stimulus keeps to all of these conditions and changes the table only under a fresh reset.

// File: rtl/rev_select.sv
module rev_select #(
  parameter int SZ_W      = 4,
  parameter int CAP_UNITS = 8,
  localparam int AW       = SZ_W + 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [1:0]      ext_sel,
  input  logic [1:0]      int_sel,
  input  logic            src_int,
  input  logic            ce,
  input  logic            oe_rst,
  input  logic            cf,
  input  logic            jtag_reconf,
  input  logic [4*SZ_W-1:0] size_tbl,
  output logic [1:0]      rev,
  output logic [AW-1:0]   start_addr,
  output logic            rev_invalid
);
  // strobe bit order: 0 ce, 1 oe_rst, 2 cf, 3 jtag
  logic [3:0] strb, s1, s2, prev, rise, fall;
  logic pu, cap, sel_ok;
  logic [1:0] sel;
  logic [SZ_W-1:0] tbl [4];
  logic [AW-1:0] pre [5];

  assign strb = {jtag_reconf, cf, oe_rst, ce};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; pu <= 1'b1;
    end else begin
      s1 <= strb; s2 <= s1; prev <= s2; pu <= 1'b0;
    end

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;
  assign cap  = pu | rise[0] | (fall[1] & ~s2[0]) | (rise[2] & ~s2[0]) | rise[3];

  always_ff @(posedge clk)
    if (!por_n)
      for (int i = 0; i < 4; i++) tbl[i] <= size_tbl[i*SZ_W +: SZ_W];

  always_comb begin
    pre[0] = '0;
    for (int i = 0; i < 4; i++) pre[i+1] = pre[i] + AW'(tbl[i]);
  end

  assign sel    = src_int ? int_sel : ext_sel;
  assign sel_ok = (tbl[sel] != '0) && (pre[{1'b0, sel} + 3'd1] <= AW'(CAP_UNITS));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rev <= 2'd0; rev_invalid <= 1'b0;
    end else if (cap) begin
      rev_invalid <= !sel_ok;
      if (sel_ok) rev <= sel;
    end

  assign start_addr = pre[{1'b0, rev}];

  assert_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    !cap |=> $stable(rev) && $stable(rev_invalid));
  assert_take_R2: assert property (@(posedge clk) disable iff (!por_n)
    cap && sel_ok |=> rev == $past(src_int ? int_sel : ext_sel) && !rev_invalid);
  assert_keep_bad_R9: assert property (@(posedge clk) disable iff (!por_n)
    cap && !sel_ok |=> $stable(rev) && rev_invalid);
  assert_gated_R4: assert property (@(posedge clk) disable iff (!por_n)
    s2[0] && !pu && !rise[3] && !rise[0] |=> $stable(rev));
  assert_base_R8: assert property (@(posedge clk) disable iff (!por_n)
    rev == 2'd0 |-> start_addr == '0);
endmodule

// File: tb/rev_select_tb.sv
module rev_select_tb;
  logic clk = 0, por_n = 0;
  logic [1:0] ext_sel = 0, int_sel = 0;
  logic src_int = 0, ce = 0, oe_rst = 1, cf = 0, jtag_reconf = 0;
  logic [15:0] size_tbl = 0;
  logic [1:0] rev;
  logic [5:0] start_addr;
  logic rev_invalid;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int req; logic [1:0] r; logic [5:0] a; logic inv; } exp_t;
  exp_t q[$];

  int m_sz[4];
  logic [1:0] m_rev;
  logic m_inv;

  always #5 clk = ~clk;

  rev_select u_dut (.clk(clk), .por_n(por_n), .ext_sel(ext_sel), .int_sel(int_sel),
    .src_int(src_int), .ce(ce), .oe_rst(oe_rst), .cf(cf), .jtag_reconf(jtag_reconf),
    .size_tbl(size_tbl), .rev(rev), .start_addr(start_addr), .rev_invalid(rev_invalid));

  function automatic int start_of(int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += m_sz[i];
    return s;
  endfunction

  function automatic void model_capture();
    logic [1:0] s = src_int ? int_sel : ext_sel;
    if (m_sz[s] != 0 && start_of(s) + m_sz[s] <= 8) begin m_rev = s; m_inv = 0; end
    else m_inv = 1;
  endfunction

  task automatic push(int req);
    exp_t e;
    e.req = req; e.r = m_rev; e.a = 6'(start_of(m_rev)); e.inv = m_inv;
    q.push_back(e);
  endtask

  always begin
    exp_t e;
    wait (q.size() > 0);
    e = q.pop_front();
    checks++;
    if (rev !== e.r || start_addr !== e.a || rev_invalid !== e.inv) begin
      errors++;
      $display("FAIL R%0d: rev=%0d addr=%0d inv=%0d expected rev=%0d addr=%0d inv=%0d",
               e.req, rev, start_addr, rev_invalid, e.r, e.a, e.inv);
    end
  end

  task automatic settle(int req);
    repeat (4) @(posedge clk);
    #1 push(req);
  endtask

  task automatic do_reset(logic [15:0] t);
    @(negedge clk);
    por_n = 0; size_tbl = t;
    for (int i = 0; i < 4; i++) m_sz[i] = t[i*4 +: 4];
    m_rev = 0; m_inv = 0;
    repeat (3) @(posedge clk);
    #1 push(1);
    @(negedge clk) por_n = 1;
    model_capture();
  endtask

  initial begin
    // R1, R2, R8: power-up capture from pins, table 2,1,3,0
    ext_sel = 2;
    do_reset(16'h0312);
    settle(1);
    push(8);
    // R7: selection change without event
    @(negedge clk) ext_sel = 1; src_int = 1; int_sel = 3;
    settle(7);
    @(negedge clk) src_int = 0;
    settle(7);
    // R10 and R3: chip-enable rising edge
    @(negedge clk) ce = 1;
    model_capture();
    @(posedge clk); @(posedge clk);
    #1 begin checks++; if (rev !== 2'd2) begin errors++;
      $display("FAIL R10: rev=%0d expected 2 after two edges", rev); end end
    @(posedge clk);
    #1 push(10);
    settle(3);
    @(negedge clk) ce = 0;   // falling edge: no capture (R7)
    settle(7);
    // R2, R4: internal bits, output-enable falling with ce low
    @(negedge clk) src_int = 1; int_sel = 0;
    @(negedge clk) oe_rst = 0; model_capture();
    settle(4);
    @(negedge clk) oe_rst = 1;
    settle(4);
    // R5, R9: configure strobe to a zero-size revision
    @(negedge clk) int_sel = 3;
    @(negedge clk) cf = 1; model_capture();
    settle(9);
    @(negedge clk) cf = 0; int_sel = 2;
    settle(5);
    // R4, R5: ignored while chip-enable high
    @(negedge clk) ce = 1; int_sel = 0; model_capture();
    settle(3);
    @(negedge clk) int_sel = 2;
    @(negedge clk) oe_rst = 0;
    settle(4);
    @(negedge clk) cf = 1;
    settle(5);
    @(negedge clk) oe_rst = 1; cf = 0;
    settle(5);
    // R6: JTAG reconfigure with chip-enable high, R9 clear of flag
    @(negedge clk) int_sel = 3;
    @(negedge clk) cf = 0;
    @(negedge clk) int_sel = 2;
    @(negedge clk) jtag_reconf = 1; model_capture();
    @(negedge clk); @(negedge clk) jtag_reconf = 0;
    settle(6);
    @(negedge clk) ce = 0;
    settle(7);
    // R9 capacity: table 4,2,3,1 -> revisions 2 and 3 overrun 8 units
    src_int = 0; ext_sel = 2;
    do_reset(16'h1324);
    settle(9);
    @(negedge clk) ext_sel = 3;
    @(negedge clk) ce = 1; model_capture();
    settle(9);
    @(negedge clk) ce = 0; ext_sel = 1;
    @(negedge clk) ce = 1; model_capture();
    settle(3);
    push(8);
    @(negedge clk) ce = 0;
    repeat (3) @(posedge clk);
    #1 done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk);
        checks++; errors++; $display("FAIL watchdog: actual hung expected done"); end
    join_any
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule